// File: doc/BRIEF.md
# Secondary Core Wake Sequencer

This block is a hardware state machine that brings one secondary processor core out of power-off. A start strobe carries a core index and a 32-bit entry address. The sequencer stores the address in a shared boot-vector register. It then walks the selected core through a fixed order: hold the core in reset, hold its L1 cache in reset, and block external debug access. Next it releases the core's power clamp in nine steps, each step shifting the mask right by one bit. It waits for the supply to settle, removes the power-off gating, and waits again. Finally it releases the core reset and enables debug access again.

The two settling waits stand for roughly 10 ms and 1 ms of real time. They are down-counters whose lengths are parameters, so a short simulation can use small values. Only one core may be in progress at a time, and `busy` reports this. A one-cycle `done` pulse marks the end of a sequence. Each per-core output is a packed vector with one field per core.

Top module: `cpu_wake_seq`

## Requirements
- R1: A start is accepted on a rising clock edge when `start` is 1, `busy` is 0 and `core_sel` is less than NCORE. At that same edge `boot_vec` takes the value of `boot_addr`.
- R2: On the edge after acceptance, the selected core's 2-bit field `rst_ctl[2c+1:2c]` becomes 0. It becomes 3 on the edge that follows the second wait.
- R3: On the second edge after acceptance, the selected core's bit `l1_run[c]` is cleared. The sequence never sets it again.
- R4: On the third edge after acceptance, the selected core's bit `dbg_en[c]` is cleared. It is set again on the last edge of the sequence, one edge after the reset release.
- R5: On nine consecutive edges after that, the selected core's field `clamp[8c+7:8c]` takes the values 0xFF, 0x7F, 0x3F, 0x1F, 0x0F, 0x07, 0x03, 0x01 and 0x00, in that order.
- R6: LONG_WAIT edges with no output change follow the last clamp step. The next edge clears `pwr_gate[c]`. SHORT_WAIT edges with no output change then pass before the reset release.
- R7: No field or bit of a core other than the selected one changes during a sequence.
- R8: `busy` is 1 from the edge that accepts a start until the last edge of the sequence. On that last edge `done` is driven to 1 for exactly one cycle, with `busy` at 0. A start that arrives while `busy` is 1 has no effect, and `boot_vec` keeps its value.
- R9: A start whose `core_sel` is NCORE or larger is ignored, and all outputs stay unchanged.
- R10: After reset, the outputs are as follows: `rst_ctl` is all 0 and `l1_run` is all 0. `dbg_en` is all 0, `clamp` is all 0xFF and `pwr_gate` is all 1. `boot_vec` is 0, and `busy` and `done` are 0.
- R11: A start presented in the cycle where `done` is 1 is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to wake the core named by `core_sel` |
| core_sel | input | SW | Index of the core to wake |
| boot_addr | input | 32 | Entry address stored in `boot_vec` |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| boot_vec | output | 32 | Shared boot-vector register |
| rst_ctl | output | 2*NCORE | Per-core reset control; 0 holds the core, 3 releases it |
| l1_run | output | NCORE | Per-core L1 cache run bit; 0 holds the cache in reset |
| dbg_en | output | NCORE | Per-core external debug-access enable |
| clamp | output | 8*NCORE | Per-core power clamp mask |
| pwr_gate | output | NCORE | Per-core power-off gating; 1 means gated off |

## Verification
The end of one sequence and the acceptance of the next can fall in the same cycle. While `done` is high, `busy` is already low, so a start held through the following edge must launch a new core. The bench waits for the `done` pulse and raises `start` for a different core in that same cycle. The reference model then requires `busy` to rise and the new core's reset field to drop, while the finished core keeps its released state. A start issued in the middle of a sequence is also checked: the model requires that it changes nothing.

// File: rtl/cpu_wake_seq.sv
module cpu_wake_seq #(
  parameter int NCORE      = 4,
  parameter int LONG_WAIT  = 500000,
  parameter int SHORT_WAIT = 50000,
  localparam int SW  = (NCORE > 1) ? $clog2(NCORE) : 1,
  localparam int MW  = (LONG_WAIT > SHORT_WAIT) ? LONG_WAIT : SHORT_WAIT,
  localparam int CTW = $clog2(MW + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [SW-1:0]      core_sel,
  input  logic [31:0]        boot_addr,
  output logic               busy,
  output logic               done,
  output logic [31:0]        boot_vec,
  output logic [2*NCORE-1:0] rst_ctl,
  output logic [NCORE-1:0]   l1_run,
  output logic [NCORE-1:0]   dbg_en,
  output logic [8*NCORE-1:0] clamp,
  output logic [NCORE-1:0]   pwr_gate
);

  typedef enum logic [3:0] {
    S_IDLE, S_HOLD, S_L1, S_DBGOFF, S_RAMP,
    S_SETTLE, S_UNGATE, S_SETTLE2, S_RELEASE, S_DBGON
  } st_t;

  st_t            st;
  logic [SW-1:0]  cur;
  logic [3:0]     step;
  logic [CTW-1:0] cnt;
  logic           accept;

  assign busy   = (st != S_IDLE);
  assign accept = start && !busy && (int'(core_sel) < NCORE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cur      <= '0;
      step     <= '0;
      cnt      <= '0;
      done     <= 1'b0;
      boot_vec <= '0;
      rst_ctl  <= '0;
      l1_run   <= '0;
      dbg_en   <= '0;
      clamp    <= '1;
      pwr_gate <= '1;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          cur      <= core_sel;
          boot_vec <= boot_addr;
          st       <= S_HOLD;
        end
        S_HOLD: begin
          rst_ctl[2*cur +: 2] <= 2'd0;
          st <= S_L1;
        end
        S_L1: begin
          l1_run[cur] <= 1'b0;
          st <= S_DBGOFF;
        end
        S_DBGOFF: begin
          dbg_en[cur] <= 1'b0;
          step <= '0;
          st <= S_RAMP;
        end
        S_RAMP: begin
          clamp[8*cur +: 8] <= 8'hFF >> step;
          step <= step + 4'd1;
          if (step == 4'd8) begin
            cnt <= CTW'(LONG_WAIT - 1);
            st  <= S_SETTLE;
          end
        end
        S_SETTLE: begin
          if (cnt == '0) st <= S_UNGATE;
          else cnt <= cnt - 1'b1;
        end
        S_UNGATE: begin
          pwr_gate[cur] <= 1'b0;
          cnt <= CTW'(SHORT_WAIT - 1);
          st  <= S_SETTLE2;
        end
        S_SETTLE2: begin
          if (cnt == '0) st <= S_RELEASE;
          else cnt <= cnt - 1'b1;
        end
        S_RELEASE: begin
          rst_ctl[2*cur +: 2] <= 2'd3;
          st <= S_DBGON;
        end
        S_DBGON: begin
          dbg_en[cur] <= 1'b1;
          done <= 1'b1;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cpu_wake_seq_chk.sv
module cpu_wake_seq_chk #(
  parameter int NCORE = 4,
  parameter int SW    = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic [SW-1:0]      core_sel,
  input logic               busy,
  input logic               done,
  input logic [31:0]        boot_vec,
  input logic [2*NCORE-1:0] rst_ctl,
  input logic [NCORE-1:0]   l1_run,
  input logic [NCORE-1:0]   dbg_en,
  input logic [8*NCORE-1:0] clamp,
  input logic [NCORE-1:0]   pwr_gate
);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_vec_on_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_vec != $past(boot_vec)) |-> $rose(busy));

  p_one_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pwr_gate ^ $past(pwr_gate)));

  p_one_dbg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dbg_en ^ $past(dbg_en)));

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    p_ramp_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clamp[8*c +: 8] != $past(clamp[8*c +: 8])) |->
      (clamp[8*c +: 8] == ($past(clamp[8*c +: 8]) >> 1)));

    p_gate_never_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(pwr_gate[c]));

    p_release_after_ungate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_ctl[2*c +: 2] == 2'd3 && $past(rst_ctl[2*c +: 2]) != 2'd3) |-> !pwr_gate[c]);
  end

endmodule

bind cpu_wake_seq cpu_wake_seq_chk #(.NCORE(NCORE), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .core_sel(core_sel),
  .busy(busy), .done(done), .boot_vec(boot_vec), .rst_ctl(rst_ctl),
  .l1_run(l1_run), .dbg_en(dbg_en), .clamp(clamp), .pwr_gate(pwr_gate)
);

// File: tb/cpu_wake_seq_tb.sv
module cpu_wake_seq_tb_top;
  localparam int NC = 3;
  localparam int LW = 20;
  localparam int SWT = 5;

  logic clk = 0, rst_n = 0, start = 0;
  logic [1:0] core_sel = 0;
  logic [31:0] boot_addr = 0;
  logic busy, done;
  logic [31:0] boot_vec;
  logic [2*NC-1:0] rst_ctl;
  logic [NC-1:0] l1_run, dbg_en, pwr_gate;
  logic [8*NC-1:0] clamp;

  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  cpu_wake_seq #(.NCORE(NC), .LONG_WAIT(LW), .SHORT_WAIT(SWT)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .core_sel(core_sel),
    .boot_addr(boot_addr), .busy(busy), .done(done), .boot_vec(boot_vec),
    .rst_ctl(rst_ctl), .l1_run(l1_run), .dbg_en(dbg_en), .clamp(clamp),
    .pwr_gate(pwr_gate));

  // reference model: a queue of per-edge actions
  int          plan[$];
  int          m_core;
  logic [31:0] m_vec;
  logic [1:0]  m_rst[NC];
  logic        m_l1[NC], m_dbg[NC], m_gate[NC], m_done;
  logic [7:0]  m_clamp[NC];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      plan.delete();
      m_vec = 0; m_done = 0; m_core = 0;
      for (int i = 0; i < NC; i++) begin
        m_rst[i] = 0; m_l1[i] = 0; m_dbg[i] = 0; m_gate[i] = 1; m_clamp[i] = 8'hFF;
      end
    end else begin
      m_done = 0;
      if (plan.size() == 0) begin
        if (start && int'(core_sel) < NC) begin
          m_core = int'(core_sel);
          m_vec = boot_addr;
          plan.push_back(1 << 8); plan.push_back(2 << 8); plan.push_back(3 << 8);
          for (int i = 0; i <= 8; i++) plan.push_back((4 << 8) | (8'hFF >> i));
          for (int i = 0; i < LW; i++) plan.push_back(0);
          plan.push_back(5 << 8);
          for (int i = 0; i < SWT; i++) plan.push_back(0);
          plan.push_back(6 << 8); plan.push_back(7 << 8);
        end
      end else begin
        int a;
        a = plan.pop_front();
        case (a >> 8)
          1: m_rst[m_core] = 2'd0;
          2: m_l1[m_core] = 0;
          3: m_dbg[m_core] = 0;
          4: m_clamp[m_core] = a[7:0];
          5: m_gate[m_core] = 0;
          6: m_rst[m_core] = 2'd3;
          7: begin m_dbg[m_core] = 1; m_done = 1; end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R1", "boot_vec", boot_vec, m_vec);
    chk("R8", "busy", busy, plan.size() != 0);
    chk("R8", "done", done, m_done);
    for (int i = 0; i < NC; i++) begin
      chk("R2/R7", "rst_ctl", rst_ctl[2*i +: 2], m_rst[i]);
      chk("R3/R7", "l1_run", l1_run[i], m_l1[i]);
      chk("R4/R7", "dbg_en", dbg_en[i], m_dbg[i]);
      chk("R5/R7", "clamp", clamp[8*i +: 8], m_clamp[i]);
      chk("R6/R7", "pwr_gate", pwr_gate[i], m_gate[i]);
    end
  end

  task automatic req(input logic [1:0] s, input logic [31:0] a);
    @(negedge clk); start = 1; core_sel = s; boot_addr = a;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "busy", busy, 0);
    chk("R10", "done", done, 0);
    chk("R10", "boot_vec", boot_vec, 0);
    chk("R10", "rst_ctl", rst_ctl, 0);
    chk("R10", "l1_run", l1_run, 0);
    chk("R10", "dbg_en", dbg_en, 0);
    chk("R10", "clamp", clamp, {NC{8'hFF}});
    chk("R10", "pwr_gate", pwr_gate, {NC{1'b1}});
    rst_n = 1;
    // R9 out-of-range index ignored
    req(2'd3, 32'hDEAD0000);
    repeat (3) @(negedge clk);
    chk("R9", "busy", busy, 0);
    chk("R9", "boot_vec", boot_vec, 0);
    // main sequence on core 2, with an intruding start (R8)
    req(2'd2, 32'h8000_1000);
    repeat (4) @(negedge clk);
    req(2'd1, 32'h1111_2222);
    @(negedge clk);
    chk("R8", "boot_vec kept", boot_vec, 32'h8000_1000);
    wait_done();
    // R11: start in the done cycle
    start = 1; core_sel = 2'd0; boot_addr = 32'h4000_0040;
    @(negedge clk); start = 0;
    chk("R11", "busy after start in done cycle", busy, 1);
    chk("R11", "boot_vec", boot_vec, 32'h4000_0040);
    wait_done();
    repeat (3) @(negedge clk);
    req(2'd1, 32'h0000_ABCD);
    wait_done();
    repeat (4) @(negedge clk);
    chk("R2", "all released", rst_ctl, 6'b111111);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 20000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule